// File: doc/BRIEF.md
# Receive Pause Countdown Timer

This block keeps the transmitter halted for the length of time a link partner asks for in a pause frame. The receive path has already decoded a pause frame into a 16-bit quantum, and it hands that quantum to the block as one item on a valid/ready input. A nonzero quantum is loaded into a countdown register. While that register holds a nonzero value, the transmit-hold output stays asserted.

The register counts down by one on each clock cycle in which the transmitter reports that it is idle. A frame already being sent therefore finishes before the pause time starts to run out. A sticky interrupt status bit is set in two cases: when the count steps down to zero, or when a pause item with zero quantum arrives. A zero-quantum item also ends any pause that is in progress at once. The status bit is cleared only by an explicit clear strobe. A masked copy of it drives the interrupt line.

The quantum input follows valid/ready rules. Ready is low during reset and goes high at the first clock edge after reset is released. After that it stays high, so the block never applies back-pressure. An item is accepted on any edge where valid and ready are both high. The source may hold valid high for several cycles, and each such cycle is a new load. Control inputs (idle, mask, clear) and status outputs are plain level signals.

Top module: `pause_rx_timer`

## Requirements
- R1: During and right after reset, tx_hold, irq_status, irq_out and qnt_ready are all 0 and the count is zero.
- R2: qnt_ready becomes 1 at the first rising edge after reset is released and stays 1 from then on.
- R3: An accepted item with a nonzero quantum and qnt_zero=0 loads the count with that value, so tx_hold is 1 from the next cycle.
- R4: While no item is accepted and the count is nonzero, the count drops by exactly one on each edge where tx_idle=1. It keeps its value on each edge where tx_idle=0.
- R5: tx_hold equals 1 exactly when the count is nonzero. An item loaded with value N and tx_idle held at 1 keeps tx_hold high for N cycles.
- R6: On the edge where the count steps from 1 to 0, irq_status is set.
- R7: An accepted item with qnt_zero=1, or with a quantum of 0, clears the count at once (tx_hold is 0 next cycle) and sets irq_status.
- R8: An accepted item that arrives while the count is running replaces the count with the new value. The decrement is skipped on that edge.
- R9: irq_status stays 1 until an edge where irq_clr=1. If a set event and irq_clr occur on the same edge, irq_status ends up 1.
- R10: irq_out is registered. After each edge it equals the new irq_status ANDed with the irq_mask_en sampled on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the whole block |
| rst_n | input | 1 | Synchronous active-low reset |
| qnt_valid | input | 1 | A decoded pause quantum is offered |
| qnt_ready | output | 1 | The block accepts a quantum this cycle |
| qnt_value | input | QNT_W | Pause quantum to load |
| qnt_zero | input | 1 | The received quantum was zero |
| tx_idle | input | 1 | No frame is being transmitted |
| irq_mask_en | input | 1 | Allows the interrupt line to follow the status bit |
| irq_clr | input | 1 | Clears the sticky status bit |
| tx_hold | output | 1 | Transmitter must stay halted |
| irq_status | output | 1 | Sticky pause-expiry status |
| irq_out | output | 1 | Masked interrupt request |

## Verification
The assertions assume three things. Inputs change only away from the clock edge. Reset is held for at least one edge before any traffic. qnt_value is a full-width known value whenever qnt_valid is high. The stimulus meets these by driving every input two nanoseconds after a rising edge, holding reset low for several cycles with valid low, and always giving an explicit quantum alongside valid. The driver covers reloads during a countdown, idle being withdrawn in the middle of a count, set and clear on the same edge, and both ways of signalling a zero quantum.

// File: rtl/pause_timer_pkg.sv
package pause_timer_pkg;

  // Outcome of the input handshake on one edge.
  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_ARM  = 2'd1,
    LD_ZERO = 2'd2
  } load_kind_e;

endpackage

// File: rtl/pause_load_decode.sv
module pause_load_decode
  import pause_timer_pkg::*;
#(
  parameter int QNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qnt_valid,
  input  logic [QNT_W-1:0] qnt_value,
  input  logic             qnt_zero,
  output logic             qnt_ready,
  output load_kind_e       kind
);

  logic rdy_q;
  logic accept;

  // Ready is asserted at the first edge after reset is released and stays high.
  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign qnt_ready = rdy_q;
  assign accept    = qnt_valid && rdy_q;

  always_comb begin
    if (!accept)
      kind = LD_NONE;
    else if (qnt_zero || (qnt_value == '0))
      kind = LD_ZERO;
    else
      kind = LD_ARM;
  end

  // R2: once ready, the block never withdraws it
  p_ready_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
    qnt_ready |=> qnt_ready);

  // R7: the zero class is produced only by a real handshake
  p_zero_needs_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LD_ZERO) |-> (qnt_valid && qnt_ready));

endmodule

// File: rtl/pause_counter.sv
module pause_counter
  import pause_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  load_kind_e   kind,
  input  logic [W-1:0] value,
  input  logic         tx_idle,
  output logic         running,
  output logic         expire
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      case (kind)
        LD_ARM:  cnt_q <= value;
        LD_ZERO: cnt_q <= '0;
        default: if ((cnt_q != '0) && tx_idle) cnt_q <= cnt_q - ONE;
      endcase
    end
  end

  assign running = (cnt_q != '0);
  assign expire  = (kind == LD_NONE) && tx_idle && (cnt_q == ONE);

  // R4: one step per idle edge
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LD_NONE && running && tx_idle) |=> (cnt_q == $past(cnt_q) - ONE));

  // R4: frozen while transmitting
  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LD_NONE && !tx_idle) |=> $stable(cnt_q));

  // R8: a load replaces the count
  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LD_ARM) |=> (cnt_q == $past(value)));

  // R7: zero load empties the count
  p_zero_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LD_ZERO) |=> !running);

endmodule

// File: rtl/pause_irq_latch.sv
module pause_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr,
  input  logic mask_en,
  output logic status,
  output logic irq
);

  logic status_d;

  // Set wins over clear.
  assign status_d = set_ev | (status & ~clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= 1'b0;
      irq    <= 1'b0;
    end else begin
      status <= status_d;
      irq    <= status_d & mask_en;
    end
  end

  // R9: sticky without clear
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !clr) |=> status);

  // R9: set beats clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> status);

  // R10: masked line never fires when the mask was off
  p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_en |=> !irq);

endmodule

// File: rtl/pause_rx_timer.sv
module pause_rx_timer
  import pause_timer_pkg::*;
#(
  parameter int QNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qnt_valid,
  output logic             qnt_ready,
  input  logic [QNT_W-1:0] qnt_value,
  input  logic             qnt_zero,
  input  logic             tx_idle,
  input  logic             irq_mask_en,
  input  logic             irq_clr,
  output logic             tx_hold,
  output logic             irq_status,
  output logic             irq_out
);

  load_kind_e kind;
  logic       expire;
  logic       set_ev;

  pause_load_decode #(.QNT_W(QNT_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .qnt_valid (qnt_valid),
    .qnt_value (qnt_value),
    .qnt_zero  (qnt_zero),
    .qnt_ready (qnt_ready),
    .kind      (kind)
  );

  pause_counter #(.W(QNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (kind),
    .value   (qnt_value),
    .tx_idle (tx_idle),
    .running (tx_hold),
    .expire  (expire)
  );

  assign set_ev = expire || (kind == LD_ZERO);

  pause_irq_latch u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ev  (set_ev),
    .clr     (irq_clr),
    .mask_en (irq_mask_en),
    .status  (irq_status),
    .irq     (irq_out)
  );

  // R6: expiry releases hold and raises status
  p_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (!tx_hold && irq_status));

  // R3: nonzero load engages hold
  p_arm_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LD_ARM) |=> tx_hold);

endmodule

// File: tb/pause_rx_timer_bench.sv
module pause_rx_timer_bench;

  localparam int QW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          qnt_valid = 1'b0;
  logic          qnt_ready;
  logic [QW-1:0] qnt_value = '0;
  logic          qnt_zero = 1'b0;
  logic          tx_idle = 1'b0;
  logic          irq_mask_en = 1'b0;
  logic          irq_clr = 1'b0;
  logic          tx_hold;
  logic          irq_status;
  logic          irq_out;

  always #10 clk = ~clk;

  pause_rx_timer #(.QNT_W(QW)) u_pause_rx_timer (
    .clk(clk), .rst_n(rst_n), .qnt_valid(qnt_valid), .qnt_ready(qnt_ready),
    .qnt_value(qnt_value), .qnt_zero(qnt_zero), .tx_idle(tx_idle),
    .irq_mask_en(irq_mask_en), .irq_clr(irq_clr), .tx_hold(tx_hold),
    .irq_status(irq_status), .irq_out(irq_out)
  );

  int compared = 0;
  int mismatched = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  // reference state
  logic [QW-1:0] m_cnt = '0;
  logic          m_st = 1'b0;
  logic          m_irq = 1'b0;
  logic          m_rdy = 1'b0;

  // Monitor: compare {ready, hold, status, irq} at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compared++;
      if ({qnt_ready, tx_hold, irq_status, irq_out} !== e) begin
        mismatched++;
        $display("FAIL %s: got rdy/hold/st/irq=%b expected %b", t,
                 {qnt_ready, tx_hold, irq_status, irq_out}, e);
      end
    end
  end

  // Driver: apply inputs for one edge, update reference, queue expectation
  task automatic cyc(input logic v, input logic [QW-1:0] val, input logic z,
                     input logic idle, input logic mask, input logic clr,
                     input string tag);
    logic set;
    qnt_valid = v; qnt_value = val; qnt_zero = z;
    tx_idle = idle; irq_mask_en = mask; irq_clr = clr;
    @(posedge clk);
    set = 1'b0;
    if (v && m_rdy) begin
      if (z || val == '0) begin m_cnt = '0; set = 1'b1; end
      else m_cnt = val;
    end else if (m_cnt != '0 && idle) begin
      if (m_cnt == 1) set = 1'b1;
      m_cnt = m_cnt - 1'b1;
    end
    m_st  = set | (m_st & ~clr);
    m_irq = m_st & mask;
    m_rdy = 1'b1;
    exp_q.push_back({m_rdy, (m_cnt != '0), m_st, m_irq});
    tag_q.push_back(tag);
    #2;
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2;
    // R1: reset state
    compared++;
    if ({qnt_ready, tx_hold, irq_status, irq_out} !== 4'b0000) begin
      mismatched++;
      $display("FAIL R1: got %b expected 0000", {qnt_ready, tx_hold, irq_status, irq_out});
    end
    rst_n = 1'b1;
    cyc(0, 0, 0, 1, 1, 0, "R2 ready rises");
    // R3 R5 R6: load 5, count down while idle
    cyc(1, 16'd5, 0, 1, 1, 0, "R3 load");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, 1, 0, "R5 R6 countdown");
    cyc(0, 0, 0, 1, 1, 1, "R9 clear");
    cyc(0, 0, 0, 1, 1, 0, "R9 stays clear");
    // R4: busy freezes count
    cyc(1, 16'd3, 0, 0, 0, 0, "R3 load busy");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, "R4 frozen");
    for (int i = 0; i < 2; i++) cyc(0, 0, 0, 1, 0, 0, "R4 step");
    cyc(0, 0, 0, 0, 0, 0, "R4 frozen again");
    cyc(0, 0, 0, 1, 0, 0, "R6 expire masked");
    cyc(0, 0, 0, 1, 1, 0, "R10 unmask");
    cyc(0, 0, 0, 1, 0, 1, "R9 clear");
    // R8: reload while running
    cyc(1, 16'd4, 0, 1, 1, 0, "R8 first load");
    cyc(0, 0, 0, 1, 1, 0, "R8 run");
    cyc(1, 16'd2, 0, 1, 1, 0, "R8 reload");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 1, 0, "R8 after reload");
    cyc(0, 0, 0, 1, 1, 1, "R9 clear");
    // R7: zero flag while running
    cyc(1, 16'd9, 0, 1, 1, 0, "R3 load");
    cyc(1, 16'd9, 1, 1, 1, 0, "R7 zero flag");
    cyc(0, 0, 0, 1, 1, 1, "R9 clear");
    // R7: zero value, with clear on the same edge (R9 set wins)
    cyc(1, 16'd7, 0, 0, 1, 0, "R3 load");
    cyc(1, 16'd0, 0, 0, 1, 1, "R7 R9 zero value with clear");
    cyc(0, 0, 0, 1, 1, 0, "R9 held");
    // R8: back-to-back valid loads, then R9 expire with clear
    cyc(1, 16'd2, 0, 1, 1, 1, "R8 stream load");
    cyc(1, 16'd1, 0, 1, 1, 0, "R8 stream load");
    cyc(0, 0, 0, 1, 1, 1, "R9 expire beats clear");
    // R5: large value, a few steps
    cyc(1, 16'hFFFF, 0, 1, 0, 1, "R5 max load");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 0, 0, "R5 max running");
    cyc(1, 0, 1, 0, 0, 0, "R7 zero ends max");
    cyc(0, 0, 0, 0, 1, 0, "R10 mask on");
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule